// File: doc/BRIEF.md
# CCD Line Timing Pulse Generator

This block produces the three per-pixel horizontal control pulses that an area-sensor readout chain needs on every line. These are a horizontal blanking pulse for the vertical shift, a black-level clamp pulse, and a digital output blanking pulse. All three are active-low. A pixel counter restarts on each line-start strobe. A line counter restarts on each frame-start strobe. Each pulse is taken from programmed start and stop pixel positions that are compared with the pixel counter.

The clamp pulse is more than a window. It is allowed only on pixels that really are optical black. These are the 4 black pixels that follow the 28 dummy pixels, and the 48 black pixels that follow the effective area. It is also allowed only on lines inside the readout region: 10 leading black lines, the programmed number of effective lines, then 2 trailing black lines. A table of up to 16 line indices, each with an enable bit, can mute the clamp on chosen lines and leave the clamp window unchanged. The output blanking pulse never overlaps an active clamp. Where its window collides with a live clamp, it is held inactive, and a sticky conflict flag records that this happened.

Top module: `ccd_line_pulse_gen`

## Requirements
- R1: While reset is held, and after it is released until a line-start strobe arrives, the outputs `hblk_n_o`, `clpob_n_o` and `pblk_n_o` are 1 and `pblk_conflict_o` is 0. Reset also clears the conflict flag.
- R2: A line-start strobe sets the pixel position to 0, and the position then advances by one on each clock. The outputs are registered, so the levels seen after a clock edge are decoded from the positions held just before that edge.
- R3: A frame-start strobe sets the line index to 0 and takes priority over a line-start strobe in the same cycle. Each other line-start strobe advances the line index by one.
- R4: A window covers pixel positions p with start <= p < stop. A window with start >= stop is empty. `hblk_n_o` is 0 inside its window on every line, whatever the frame region.
- R5: `clpob_n_o` is 0 only when the pixel lies in its window and also in an optical-black field. The front field is positions [28, 32). The rear field is positions [32+E, 80+E), where E is `cfg_eff_pix_i`. The dummy pixels and the effective pixels never clamp.
- R6: The clamp is suppressed on every line index at or above 12+L, where L is `cfg_eff_lines_i`. Those are vertical blanking and sensor-gate lines.
- R7: If any mask entry k has `mask_en_i[k]`=1 and a line value (bits [16k+15:16k] of `mask_line_i`) equal to the current line, `clpob_n_o` stays 1 for that whole line. An entry whose enable bit is 0 has no effect.
- R8: With `pblk_en_i`=1, `pblk_n_o` is 0 inside its window. With `pblk_en_i`=0 it stays 1.
- R9: `pblk_n_o` is forced to 1 at every position where the clamp is active, so the two outputs are never 0 together.
- R10: `pblk_conflict_o` goes to 1 when an enabled output blanking window meets an active clamp, and it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hd_i | input | 1 | Line-start strobe |
| fs_i | input | 1 | Frame-start strobe |
| cfg_eff_pix_i | input | 16 | Effective pixels per line |
| cfg_eff_lines_i | input | 16 | Effective lines per frame |
| hblk_start_i | input | 16 | Horizontal blanking first pixel |
| hblk_stop_i | input | 16 | Horizontal blanking end pixel (exclusive) |
| clp_start_i | input | 16 | Clamp first pixel |
| clp_stop_i | input | 16 | Clamp end pixel (exclusive) |
| pblk_en_i | input | 1 | Output blanking enable |
| pblk_start_i | input | 16 | Output blanking first pixel |
| pblk_stop_i | input | 16 | Output blanking end pixel (exclusive) |
| mask_line_i | input | 256 | Sixteen 16-bit clamp mask line indices |
| mask_en_i | input | 16 | Enable bit of each mask entry |
| hblk_n_o | output | 1 | Horizontal blanking, active low |
| clpob_n_o | output | 1 | Black-level clamp, active low |
| pblk_n_o | output | 1 | Output blanking, active low |
| pblk_conflict_o | output | 1 | Sticky blanking/clamp collision flag |

## Verification
The clamp and the output blanking pulse can both want the same pixel. The bench provokes this by placing the blanking window [90, 110) across the tail of the rear black field, which ends at position 95. At positions 90 to 95 it expects the blanking output to stay high while the clamp is low. From position 96 on it expects blanking to go low. It also expects the conflict flag to be set and to stay set over later clean lines until the next reset. A checker additionally watches every cycle for the two outputs being low together.

// File: rtl/ccdlp_pkg.sv
package ccdlp_pkg;
  localparam int POS_W = 16;
  typedef logic [POS_W-1:0] pos_t;
  typedef logic [POS_W:0]   ext_t;

  // start-inclusive, stop-exclusive span test
  function automatic logic in_span(pos_t p, pos_t lo, pos_t hi);
    return (p >= lo) && (p < hi);
  endfunction

  // optical-black pixel: front field after the dummies, rear field after the image
  function automatic logic ob_pixel(pos_t p, pos_t eff, int dummy, int front, int rear);
    ext_t front_lo;
    ext_t front_hi;
    ext_t rear_hi;
    ext_t pe;
    pe       = {1'b0, p};
    front_lo = ext_t'(dummy);
    front_hi = ext_t'(dummy + front);
    rear_hi  = front_hi + {1'b0, eff} + ext_t'(rear);
    return ((pe >= front_lo) && (pe < front_hi)) ||
           ((pe >= front_hi + {1'b0, eff}) && (pe < rear_hi));
  endfunction

  // line belongs to the readout region (leading OB, image, trailing OB)
  function automatic logic readout_row(pos_t ln, pos_t eff_lines, int lead, int trail);
    return {1'b0, ln} < (ext_t'(lead + trail) + {1'b0, eff_lines});
  endfunction
endpackage

// File: rtl/ccdlp_counters.sv
module ccdlp_counters
  import ccdlp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hd_i,
  input  logic fs_i,
  output pos_t pix_o,
  output pos_t line_o
);
  pos_t pix_q;
  pos_t line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= '1;
      line_q <= '1;
    end else begin
      if (hd_i)
        pix_q <= '0;
      else if (pix_q != '1)
        pix_q <= pix_q + pos_t'(1);
      if (fs_i)
        line_q <= '0;
      else if (hd_i && (line_q != '1))
        line_q <= line_q + pos_t'(1);
    end
  end

  assign pix_o  = pix_q;
  assign line_o = line_q;
endmodule

// File: rtl/ccdlp_window.sv
module ccdlp_window
  import ccdlp_pkg::*;
(
  input  pos_t pos_i,
  input  pos_t start_i,
  input  pos_t stop_i,
  output logic hit_o
);
  assign hit_o = in_span(pos_i, start_i, stop_i);
endmodule

// File: rtl/ccdlp_line_mask.sv
module ccdlp_line_mask
  import ccdlp_pkg::*;
#(
  parameter int MASK_N = 16
) (
  input  pos_t                    line_i,
  input  logic [MASK_N*POS_W-1:0] mask_line_i,
  input  logic [MASK_N-1:0]       mask_en_i,
  output logic                    masked_o
);
  logic [MASK_N-1:0] entry_hit;

  for (genvar k = 0; k < MASK_N; k++) begin : g_entry
    assign entry_hit[k] = mask_en_i[k] && (mask_line_i[k*POS_W +: POS_W] == line_i);
  end

  assign masked_o = |entry_hit;
endmodule

// File: rtl/ccd_line_pulse_gen.sv
module ccd_line_pulse_gen
  import ccdlp_pkg::*;
#(
  parameter int MASK_N         = 16,
  parameter int DUMMY_PIX      = 28,
  parameter int FRONT_OB_PIX   = 4,
  parameter int REAR_OB_PIX    = 48,
  parameter int FRONT_OB_LINES = 10,
  parameter int REAR_OB_LINES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hd_i,
  input  logic                    fs_i,
  input  logic [POS_W-1:0]        cfg_eff_pix_i,
  input  logic [POS_W-1:0]        cfg_eff_lines_i,
  input  logic [POS_W-1:0]        hblk_start_i,
  input  logic [POS_W-1:0]        hblk_stop_i,
  input  logic [POS_W-1:0]        clp_start_i,
  input  logic [POS_W-1:0]        clp_stop_i,
  input  logic                    pblk_en_i,
  input  logic [POS_W-1:0]        pblk_start_i,
  input  logic [POS_W-1:0]        pblk_stop_i,
  input  logic [MASK_N*POS_W-1:0] mask_line_i,
  input  logic [MASK_N-1:0]       mask_en_i,
  output logic                    hblk_n_o,
  output logic                    clpob_n_o,
  output logic                    pblk_n_o,
  output logic                    pblk_conflict_o
);
  localparam int NUM_WIN = 3;
  localparam int W_HBLK  = 0;
  localparam int W_CLP   = 1;
  localparam int W_PBLK  = 2;

  pos_t pix_q;
  pos_t line_q;

  ccdlp_counters u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .hd_i   (hd_i),
    .fs_i   (fs_i),
    .pix_o  (pix_q),
    .line_o (line_q)
  );

  pos_t               win_start [NUM_WIN];
  pos_t               win_stop  [NUM_WIN];
  logic [NUM_WIN-1:0] win_hit;

  assign win_start[W_HBLK] = hblk_start_i;
  assign win_stop[W_HBLK]  = hblk_stop_i;
  assign win_start[W_CLP]  = clp_start_i;
  assign win_stop[W_CLP]   = clp_stop_i;
  assign win_start[W_PBLK] = pblk_start_i;
  assign win_stop[W_PBLK]  = pblk_stop_i;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    ccdlp_window u_win (
      .pos_i   (pix_q),
      .start_i (win_start[w]),
      .stop_i  (win_stop[w]),
      .hit_o   (win_hit[w])
    );
  end

  logic line_masked;

  ccdlp_line_mask #(.MASK_N(MASK_N)) u_mask (
    .line_i      (line_q),
    .mask_line_i (mask_line_i),
    .mask_en_i   (mask_en_i),
    .masked_o    (line_masked)
  );

  // named events for the checker
  logic hblk_hit;
  logic ob_pix;
  logic readout_line;
  logic clamp_on;
  logic pblk_req;
  logic pblk_clash;

  assign hblk_hit     = win_hit[W_HBLK];
  assign ob_pix       = ob_pixel(pix_q, cfg_eff_pix_i, DUMMY_PIX, FRONT_OB_PIX, REAR_OB_PIX);
  assign readout_line = readout_row(line_q, cfg_eff_lines_i, FRONT_OB_LINES, REAR_OB_LINES);
  assign clamp_on     = win_hit[W_CLP] && ob_pix && readout_line && !line_masked;
  assign pblk_req     = pblk_en_i && win_hit[W_PBLK];
  assign pblk_clash   = pblk_req && clamp_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hblk_n_o        <= 1'b1;
      clpob_n_o       <= 1'b1;
      pblk_n_o        <= 1'b1;
      pblk_conflict_o <= 1'b0;
    end else begin
      hblk_n_o        <= !hblk_hit;
      clpob_n_o       <= !clamp_on;
      pblk_n_o        <= !(pblk_req && !clamp_on);
      pblk_conflict_o <= pblk_conflict_o || pblk_clash;
    end
  end
endmodule

// File: rtl/ccdlp_checker.sv
module ccdlp_checker
  import ccdlp_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic hd_i,
  input logic fs_i,
  input pos_t pix_q,
  input pos_t line_q,
  input logic hblk_hit,
  input logic ob_pix,
  input logic readout_line,
  input logic line_masked,
  input logic pblk_clash,
  input logic hblk_n_o,
  input logic clpob_n_o,
  input logic pblk_n_o,
  input logic pblk_conflict_o
);
  // R2
  hd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hd_i |=> (pix_q == '0));

  // R3
  fs_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_i |=> (line_q == '0));

  // R4
  hblk_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hblk_n_o |-> $past(hblk_hit));

  // R5
  clamp_ob_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clpob_n_o |-> $past(ob_pix));

  // R6
  clamp_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clpob_n_o |-> $past(readout_line));

  // R7
  clamp_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_masked |=> clpob_n_o);

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!pblk_n_o && !clpob_n_o));

  // R10
  conflict_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pblk_clash |=> pblk_conflict_o);

  // R10
  conflict_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pblk_conflict_o |=> pblk_conflict_o);
endmodule

bind ccd_line_pulse_gen ccdlp_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .hd_i            (hd_i),
  .fs_i            (fs_i),
  .pix_q           (pix_q),
  .line_q          (line_q),
  .hblk_hit        (hblk_hit),
  .ob_pix          (ob_pix),
  .readout_line    (readout_line),
  .line_masked     (line_masked),
  .pblk_clash      (pblk_clash),
  .hblk_n_o        (hblk_n_o),
  .clpob_n_o       (clpob_n_o),
  .pblk_n_o        (pblk_n_o),
  .pblk_conflict_o (pblk_conflict_o)
);

// File: tb/ccd_line_pulse_gen_bench.sv
`timescale 1ns/1ps
module ccd_line_pulse_gen_bench;
  localparam int MN = 16;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hd = 1'b0;
  logic fs = 1'b0;
  logic [PW-1:0] eff_pix, eff_lines;
  logic [PW-1:0] hb_s, hb_e, cl_s, cl_e, pb_s, pb_e;
  logic pb_en;
  logic [MN*PW-1:0] m_line;
  logic [MN-1:0] m_en;
  logic hblk_n, clpob_n, pblk_n, conflict;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ccd_line_pulse_gen u_ccd_line_pulse_gen (
    .clk (clk), .rst_n (rst_n), .hd_i (hd), .fs_i (fs),
    .cfg_eff_pix_i (eff_pix), .cfg_eff_lines_i (eff_lines),
    .hblk_start_i (hb_s), .hblk_stop_i (hb_e),
    .clp_start_i (cl_s), .clp_stop_i (cl_e),
    .pblk_en_i (pb_en), .pblk_start_i (pb_s), .pblk_stop_i (pb_e),
    .mask_line_i (m_line), .mask_en_i (m_en),
    .hblk_n_o (hblk_n), .clpob_n_o (clpob_n), .pblk_n_o (pblk_n),
    .pblk_conflict_o (conflict)
  );

  // {line, pixel, hblk_n, clpob_n, pblk_n}
  localparam int NV = 15;
  localparam logic [18:0] VEC [NV] = '{
    {8'd0,  8'd0,   1'b0, 1'b1, 1'b1},
    {8'd0,  8'd19,  1'b0, 1'b1, 1'b1},
    {8'd0,  8'd20,  1'b1, 1'b1, 1'b1},
    {8'd0,  8'd47,  1'b1, 1'b1, 1'b1},
    {8'd0,  8'd48,  1'b1, 1'b0, 1'b1},
    {8'd0,  8'd92,  1'b1, 1'b0, 1'b1},
    {8'd0,  8'd95,  1'b1, 1'b0, 1'b1},
    {8'd0,  8'd96,  1'b1, 1'b1, 1'b0},
    {8'd0,  8'd109, 1'b1, 1'b1, 1'b0},
    {8'd0,  8'd110, 1'b1, 1'b1, 1'b1},
    {8'd3,  8'd60,  1'b1, 1'b1, 1'b1},
    {8'd5,  8'd60,  1'b1, 1'b0, 1'b1},
    {8'd15, 8'd60,  1'b1, 1'b0, 1'b1},
    {8'd16, 8'd60,  1'b1, 1'b1, 1'b1},
    {8'd16, 8'd5,   1'b0, 1'b1, 1'b1}
  };
  string VREQ [NV] = '{"R4", "R4", "R4", "R5", "R5", "R9", "R5", "R8",
                       "R8", "R4", "R7", "R7", "R6", "R6", "R4"};

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // R2 R3: frame start with line start gives line 0; each further strobe adds a line
  task automatic go_to(int ln, int px);
    @(negedge clk); fs = 1'b1; hd = 1'b1;
    @(negedge clk); fs = 1'b0;
    for (int i = 0; i < ln; i++) @(negedge clk);
    hd = 1'b0;
    repeat (px + 1) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", hblk_n, 1'b1, "hblk in reset");
    chk("R1", clpob_n, 1'b1, "clpob in reset");
    chk("R1", pblk_n, 1'b1, "pblk in reset");
    chk("R1", conflict, 1'b0, "flag in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", hblk_n, 1'b1, "hblk before first line");
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    eff_pix = 16; eff_lines = 4;
    hb_s = 0;  hb_e = 20;
    cl_s = 40; cl_e = 100;
    pb_en = 1'b1; pb_s = 90; pb_e = 110;
    m_line = '0; m_en = '0;
    m_line[0*PW +: PW] = 16'd3; m_en[0] = 1'b1;
    m_line[1*PW +: PW] = 16'd5; m_en[1] = 1'b0;

    do_reset();

    for (int v = 0; v < NV; v++) begin
      go_to(int'(VEC[v][18:11]), int'(VEC[v][10:3]));
      chk(VREQ[v], hblk_n,  VEC[v][2], $sformatf("hblk line %0d pix %0d", VEC[v][18:11], VEC[v][10:3]));
      chk(VREQ[v], clpob_n, VEC[v][1], $sformatf("clpob line %0d pix %0d", VEC[v][18:11], VEC[v][10:3]));
      chk(VREQ[v], pblk_n,  VEC[v][0], $sformatf("pblk line %0d pix %0d", VEC[v][18:11], VEC[v][10:3]));
    end

    // R10: overlap seen at pixels 90..95 sets the flag, which holds on later lines
    chk("R10", conflict, 1'b1, "flag after overlap");
    go_to(16, 30);
    chk("R10", conflict, 1'b1, "flag stays set");

    // R8: disabled output blanking stays high inside its window
    pb_en = 1'b0;
    go_to(1, 100);
    chk("R8", pblk_n, 1'b1, "pblk disabled");
    pb_en = 1'b1;

    // R4: empty window
    hb_s = 5; hb_e = 5;
    go_to(1, 5);
    chk("R4", hblk_n, 1'b1, "empty hblk window");
    hb_s = 0; hb_e = 20;

    // R5: front optical-black field only, dummy and image never clamp
    cl_s = 0; cl_e = 200; pb_en = 1'b0;
    go_to(1, 29);
    chk("R5", clpob_n, 1'b0, "front OB pixel 29");
    go_to(1, 27);
    chk("R5", clpob_n, 1'b1, "dummy pixel 27");
    go_to(1, 32);
    chk("R5", clpob_n, 1'b1, "image pixel 32");
    go_to(1, 40);
    chk("R5", clpob_n, 1'b1, "image pixel 40");

    // R1: reset clears the sticky flag
    do_reset();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule